// File: doc/BRIEF.md
# Event timer register front end

This block is the bus-facing register file of a three-channel event timer. It decodes a 1 KiB register window on a simple 32-bit read/write bus. It holds a 64-bit free-running main counter, a fixed capability word pair, a global configuration register and a status word. It also stores the configuration and comparator words of every channel, so the per-channel compare logic elsewhere in the chip can consume them.

Software starts and stops the main counter with a global enable bit. Stopping freezes the count, and restarting continues from the frozen value. Changes of that bit are turned into one-cycle arm and disarm strobes for the channels. Writes to a channel's registers produce write strobes for that channel. A comparator write while the timer runs also arms that channel.

The expiry pulses coming back from the channels are gated by the channel's and the global interrupt enables. They are then steered onto one of 32 interrupt lines. Normally each channel picks its line through its route field. A legacy-routing bit overrides this for channels 0 and 1.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset the reads return the following values. Word 0x000 reads 0x8086A201: bit 15 is legacy-capable, bit 13 is 64-bit counter, bits 12:8 are the channel count minus one, and bits 7:0 are 0x01. Word 0x004 reads the tick period, default 0x00989680. The global configuration (0x010) and both counter halves (0x0F0 low, 0x0F4 high) read 0. Every channel configuration reads 0x30, its upper word reads 0x4, and both comparator words read 0xFFFFFFFF.
- R2: The main counter increments by one on every clock while global configuration bit 0 (enable) is 1. Clearing enable freezes the count. Setting it again resumes from the frozen value, with a carry from the low half into the high half.
- R3: Writes to 0x0F0 or 0x0F4 replace only that 32-bit half of the counter. This applies whether the counter is stopped or running.
- R4: Only bits 1:0 of the global configuration are writable, and the other bits read 0. Word 0x014 reads 0 and ignores writes. Words 0x000, 0x004 and the status word 0x020 are read-only, and status reads 0.
- R5: Channel n has its registers at 0x100 + 0x20·n. The registers within each channel are as follows:
  - +0x00 is the configuration word. Writable mask 0x3F0C: bit 2 is interrupt enable, bit 3 is periodic, bit 8 is 32-bit mode, and bits 13:9 are the route. Read-only bits 5:4 always read 1.
  - +0x04 is read-only and reads 0x4.
  - +0x08 and +0x0C are the comparator low and high halves, and read back what was written.
  - +0x10 reads 0.
- R6: A channel slot at or beyond the implemented count (3..23) reads 0, and writes to it change no implemented channel.
- R7: On a write that sets enable while it was clear, ch_arm pulses for exactly one cycle for each channel whose comparator is not all ones. On a write that clears a set enable, ch_disarm pulses on all channels for one cycle. Both pulses appear in the cycle after the write edge.
- R8: The cycle after a write edge, ch_cfg_wr pulses for a channel configuration write and ch_cmp_wr for a comparator write (either half). A comparator write while enabled also pulses ch_arm for that channel.
- R9: A configuration write with bit 8 (32-bit mode) set clears the upper comparator half of that channel.
- R10: A channel pulse reaches irq_lines one cycle later, on the line given by its route field. It does so only if its interrupt enable and the global enable are both 1. With legacy routing (global bit 1), channel 0 drives line 0 and channel 1 drives line 8, while channel 2 keeps its route field.
- R11: legacy_mode equals global configuration bit 1.
- R12: rd_data is updated in the cycle after a read enable and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| ch_irq_pulse | input | 3 | Expiry pulse from each channel |
| rd_data | output | 32 | Registered read data |
| cnt_value | output | 64 | Main counter value |
| ch_cfg | output | 96 | Configuration word of each channel |
| ch_cmp | output | 192 | Comparator of each channel |
| ch_cfg_wr | output | 3 | Per-channel configuration write strobe |
| ch_cmp_wr | output | 3 | Per-channel comparator write strobe |
| ch_arm | output | 3 | Per-channel arm strobe |
| ch_disarm | output | 3 | Per-channel disarm strobe |
| legacy_mode | output | 1 | Legacy routing active |
| irq_lines | output | 32 | Interrupt line bank |

## Verification
A wrong stored configuration or comparator bit appears on the next read of that word, one cycle after the read enable. The same fault also appears in the arm strobes at the next enable edge, because arming depends on the comparator not being all ones. A counter that fails to stop or carry shows as a wrong frozen value on the first read after disable. Routing or gating errors show as a pulse on the wrong line, or a missing pulse, exactly one cycle after the channel pulse. Every one of these faults is therefore visible at the ports within two cycles of the stimulus that exposes it.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int HALF_W  = 32;
  localparam int ROUTE_W = 5;

  localparam logic [9:0] A_ID     = 10'h000;
  localparam logic [9:0] A_PERIOD = 10'h004;
  localparam logic [9:0] A_GCFG   = 10'h010;
  localparam logic [9:0] A_GCFG_H = 10'h014;
  localparam logic [9:0] A_STATUS = 10'h020;
  localparam logic [9:0] A_CNT_LO = 10'h0F0;
  localparam logic [9:0] A_CNT_HI = 10'h0F4;

  localparam logic [2:0] W_CFG    = 3'd0;
  localparam logic [2:0] W_CAP    = 3'd1;
  localparam logic [2:0] W_CMP_LO = 3'd2;
  localparam logic [2:0] W_CMP_HI = 3'd3;

  localparam int B_EN     = 0;
  localparam int B_LEGACY = 1;
  localparam int B_INT_EN = 2;
  localparam int B_MODE32 = 8;
  localparam int B_ROUTE  = 9;

  localparam logic [HALF_W-1:0] GCFG_WMASK = 32'h0000_0003;
  localparam logic [HALF_W-1:0] CH_WMASK   = 32'h0000_3F0C;
  localparam logic [HALF_W-1:0] CH_RO_SET  = 32'h0000_0030;
  localparam logic [HALF_W-1:0] CH_CAP_HI  = 32'h0000_0004;
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo)         cnt_d[HALF_W-1:0]     = wdata;
    else if (wr_hi)    cnt_d[CNT_W-1:HALF_W] = wdata;
    else if (count_en) cnt_d                 = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !wr_lo && !wr_hi) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  a_r3_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_q[HALF_W-1:0] == $past(wdata)));
endmodule

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
  import evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [2:0]        word,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] cfg,
  output logic [2*HALF_W-1:0] cmp,
  output logic [HALF_W-1:0] rdata
);
  logic [HALF_W-1:0]   cfg_q, cfg_d;
  logic [2*HALF_W-1:0] cmp_q, cmp_d;
  logic wr_cfg, wr_lo, wr_hi;

  assign wr_cfg = sel && we && (word == W_CFG);
  assign wr_lo  = sel && we && (word == W_CMP_LO);
  assign wr_hi  = sel && we && (word == W_CMP_HI);

  always_comb begin
    cfg_d = cfg_q;
    cmp_d = cmp_q;
    if (wr_cfg) begin
      cfg_d = (wdata & CH_WMASK) | (cfg_q & ~CH_WMASK);
      if (wdata[B_MODE32]) cmp_d[2*HALF_W-1:HALF_W] = '0;
    end
    if (wr_lo) cmp_d[HALF_W-1:0]        = wdata;
    if (wr_hi) cmp_d[2*HALF_W-1:HALF_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CH_RO_SET;
      cmp_q <= '1;
    end else begin
      cfg_q <= cfg_d;
      cmp_q <= cmp_d;
    end
  end

  always_comb begin
    unique case (word)
      W_CFG:    rdata = cfg_q;
      W_CAP:    rdata = CH_CAP_HI;
      W_CMP_LO: rdata = cmp_q[HALF_W-1:0];
      W_CMP_HI: rdata = cmp_q[2*HALF_W-1:HALF_W];
      default:  rdata = '0;
    endcase
  end

  assign cfg = cfg_q;
  assign cmp = cmp_q;

  a_r9_mode32_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && wdata[B_MODE32]) |=> (cmp_q[2*HALF_W-1:HALF_W] == '0));
  a_r5_ro_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cfg_q[5:4] == 2'b11));
  a_r5_cmp_lo: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cmp_q[HALF_W-1:0] == $past(wdata)));
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route #(
  parameter int NUM_CH  = 3,
  parameter int ROUTE_W = 5,
  localparam int NUM_IRQ = 1 << ROUTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         fire,
  input  logic [NUM_CH*ROUTE_W-1:0] route,
  input  logic                      legacy,
  output logic [NUM_IRQ-1:0]        lines
);
  logic [ROUTE_W-1:0] dest [NUM_CH];
  logic [NUM_IRQ-1:0] lines_q, lines_d;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dest
    if (c == 0) begin : g_l0
      assign dest[c] = legacy ? ROUTE_W'(0) : route[c*ROUTE_W +: ROUTE_W];
    end else if (c == 1) begin : g_l1
      assign dest[c] = legacy ? ROUTE_W'(8) : route[c*ROUTE_W +: ROUTE_W];
    end else begin : g_pl
      assign dest[c] = route[c*ROUTE_W +: ROUTE_W];
    end
  end

  always_comb begin
    lines_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (fire[c]) lines_d[dest[c]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= lines_d;
  end

  assign lines = lines_q;

  a_r10_legacy0: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && fire[0]) |=> lines_q[0]);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == '0) |=> (lines_q == '0));
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter logic [31:0] TICK_FS = 32'h0098_9680,
  localparam int NUM_IRQ = 1 << ROUTE_W,
  localparam int CNT_W   = 2 * HALF_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [9:0]                 bus_addr,
  input  logic [HALF_W-1:0]          bus_wdata,
  input  logic                       bus_we,
  input  logic                       bus_re,
  input  logic [NUM_CH-1:0]          ch_irq_pulse,
  output logic [HALF_W-1:0]          rd_data,
  output logic [CNT_W-1:0]           cnt_value,
  output logic [NUM_CH*HALF_W-1:0]   ch_cfg,
  output logic [NUM_CH*CNT_W-1:0]    ch_cmp,
  output logic [NUM_CH-1:0]          ch_cfg_wr,
  output logic [NUM_CH-1:0]          ch_cmp_wr,
  output logic [NUM_CH-1:0]          ch_arm,
  output logic [NUM_CH-1:0]          ch_disarm,
  output logic                       legacy_mode,
  output logic [NUM_IRQ-1:0]         irq_lines
);
  localparam logic [HALF_W-1:0] CAP_LO =
    {16'h8086, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), 8'h01};

  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_m} <= 2'b00;
    else        {rst_s, rst_m} <= {rst_m, 1'b1};
  end

  logic       word_ok, in_chan;
  logic [4:0] slot;
  logic [2:0] word;
  assign word_ok = (bus_addr[1:0] == 2'b00);
  assign in_chan = (bus_addr[9:8] != 2'b00) && word_ok;
  assign slot    = bus_addr[9:5] - 5'd8;
  assign word    = bus_addr[4:2];

  logic gcfg_we, cnt_lo_we, cnt_hi_we;
  assign gcfg_we   = bus_we && (bus_addr == A_GCFG);
  assign cnt_lo_we = bus_we && (bus_addr == A_CNT_LO);
  assign cnt_hi_we = bus_we && (bus_addr == A_CNT_HI);

  logic [1:0] gcfg_q, gcfg_d;
  logic en_q, rise, fall;
  assign en_q = gcfg_q[B_EN];

  always_comb begin
    gcfg_d = gcfg_q;
    if (gcfg_we) gcfg_d = bus_wdata[1:0] & GCFG_WMASK[1:0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) gcfg_q <= '0;
    else        gcfg_q <= gcfg_d;
  end

  assign rise = gcfg_we &&  bus_wdata[B_EN] && !en_q;
  assign fall = gcfg_we && !bus_wdata[B_EN] &&  en_q;

  evt_main_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .count_en(en_q),
    .wr_lo(cnt_lo_we), .wr_hi(cnt_hi_we), .wdata(bus_wdata),
    .cnt(cnt_value)
  );

  logic [NUM_CH-1:0]   sel, cfg_now, cmp_now, arm_d;
  logic [HALF_W-1:0]   ch_rd [NUM_CH];
  logic [NUM_CH*ROUTE_W-1:0] route;
  logic [NUM_CH-1:0]   fire;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign sel[c] = in_chan && (slot == 5'(c));
    evt_chan_regs u_regs (
      .clk(clk), .rst_n(rst_s), .sel(sel[c]), .we(bus_we), .word(word),
      .wdata(bus_wdata),
      .cfg(ch_cfg[c*HALF_W +: HALF_W]),
      .cmp(ch_cmp[c*CNT_W +: CNT_W]),
      .rdata(ch_rd[c])
    );
    assign cfg_now[c] = sel[c] && bus_we && (word == W_CFG);
    assign cmp_now[c] = sel[c] && bus_we &&
                        ((word == W_CMP_LO) || (word == W_CMP_HI));
    assign arm_d[c]   = (rise && (ch_cmp[c*CNT_W +: CNT_W] != '1)) ||
                        (cmp_now[c] && en_q);
    assign route[c*ROUTE_W +: ROUTE_W] = ch_cfg[c*HALF_W + B_ROUTE +: ROUTE_W];
    assign fire[c] = ch_irq_pulse[c] && ch_cfg[c*HALF_W + B_INT_EN] && en_q;
  end

  logic [NUM_CH-1:0] cfg_wr_q, cmp_wr_q, arm_q, disarm_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cfg_wr_q <= '0;
      cmp_wr_q <= '0;
      arm_q    <= '0;
      disarm_q <= '0;
    end else begin
      cfg_wr_q <= cfg_now;
      cmp_wr_q <= cmp_now;
      arm_q    <= arm_d;
      disarm_q <= {NUM_CH{fall}};
    end
  end
  assign ch_cfg_wr = cfg_wr_q;
  assign ch_cmp_wr = cmp_wr_q;
  assign ch_arm    = arm_q;
  assign ch_disarm = disarm_q;

  logic [HALF_W-1:0] rd_d, rd_q, chan_rd;
  always_comb begin
    chan_rd = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel[c]) chan_rd = chan_rd | ch_rd[c];
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (bus_re) begin
      if (in_chan) rd_d = chan_rd;
      else begin
        unique case (bus_addr)
          A_ID:     rd_d = CAP_LO;
          A_PERIOD: rd_d = TICK_FS;
          A_GCFG:   rd_d = {{(HALF_W-2){1'b0}}, gcfg_q};
          A_GCFG_H: rd_d = '0;
          A_STATUS: rd_d = '0;
          A_CNT_LO: rd_d = cnt_value[HALF_W-1:0];
          A_CNT_HI: rd_d = cnt_value[CNT_W-1:HALF_W];
          default:  rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rd_q <= '0;
    else        rd_q <= rd_d;
  end
  assign rd_data = rd_q;

  assign legacy_mode = gcfg_q[B_LEGACY];

  evt_irq_route #(.NUM_CH(NUM_CH), .ROUTE_W(ROUTE_W)) u_route (
    .clk(clk), .rst_n(rst_s), .fire(fire), .route(route),
    .legacy(gcfg_q[B_LEGACY]), .lines(irq_lines)
  );

  a_r7_disarm_all: assert property (@(posedge clk) disable iff (!rst_s)
    (ch_disarm != '0) |-> (ch_disarm == '1));
  a_r7_arm_excl: assert property (@(posedge clk) disable iff (!rst_s)
    !((ch_arm != '0) && (ch_disarm != '0)));
  a_r7_rise_arms: assert property (@(posedge clk) disable iff (!rst_s)
    (rise && (ch_cmp[CNT_W-1:0] != '1)) |=> ch_arm[0]);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !bus_re |=> $stable(rd_data));
  a_r11_legacy: assert property (@(posedge clk) disable iff (!rst_s)
    gcfg_we |=> (legacy_mode == $past(bus_wdata[B_LEGACY])));
endmodule

// File: tb/evt_timer_regs_bench.sv
module evt_timer_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [2:0]  ch_irq_pulse = '0;
  logic [31:0] rd_data;
  logic [63:0] cnt_value;
  logic [95:0] ch_cfg;
  logic [191:0] ch_cmp;
  logic [2:0]  ch_cfg_wr, ch_cmp_wr, ch_arm, ch_disarm;
  logic        legacy_mode;
  logic [31:0] irq_lines;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_timer_regs u_evt_timer_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .ch_irq_pulse(ch_irq_pulse),
    .rd_data(rd_data), .cnt_value(cnt_value), .ch_cfg(ch_cfg), .ch_cmp(ch_cmp),
    .ch_cfg_wr(ch_cfg_wr), .ch_cmp_wr(ch_cmp_wr), .ch_arm(ch_arm),
    .ch_disarm(ch_disarm), .legacy_mode(legacy_mode), .irq_lines(irq_lines)
  );

  // {req[3:0], is_read, addr[9:0], data[31:0]}
  localparam int NV = 39;
  localparam logic [46:0] VEC [NV] = '{
    // R1 reset state
    {4'd1, 1'b1, 10'h000, 32'h8086A201},
    {4'd1, 1'b1, 10'h004, 32'h00989680},
    {4'd1, 1'b1, 10'h010, 32'h00000000},
    {4'd1, 1'b1, 10'h0F0, 32'h00000000},
    {4'd1, 1'b1, 10'h0F4, 32'h00000000},
    {4'd1, 1'b1, 10'h100, 32'h00000030},
    {4'd1, 1'b1, 10'h104, 32'h00000004},
    {4'd1, 1'b1, 10'h108, 32'hFFFFFFFF},
    {4'd1, 1'b1, 10'h14C, 32'hFFFFFFFF},
    // R4 global configuration masking and read-only words
    {4'd4, 1'b0, 10'h010, 32'hFFFFFFFE},
    {4'd4, 1'b1, 10'h010, 32'h00000002},
    {4'd4, 1'b0, 10'h010, 32'h00000000},
    {4'd4, 1'b0, 10'h014, 32'hFFFFFFFF},
    {4'd4, 1'b1, 10'h014, 32'h00000000},
    {4'd4, 1'b0, 10'h000, 32'h12345678},
    {4'd4, 1'b1, 10'h000, 32'h8086A201},
    {4'd4, 1'b0, 10'h020, 32'hFFFFFFFF},
    {4'd4, 1'b1, 10'h020, 32'h00000000},
    // R5 channel 1 layout
    {4'd5, 1'b0, 10'h120, 32'hFFFFFFFF},
    {4'd5, 1'b1, 10'h120, 32'h00003F3C},
    {4'd5, 1'b0, 10'h124, 32'h00000000},
    {4'd5, 1'b1, 10'h124, 32'h00000004},
    {4'd5, 1'b0, 10'h130, 32'hFFFFFFFF},
    {4'd5, 1'b1, 10'h130, 32'h00000000},
    {4'd5, 1'b0, 10'h128, 32'h12345678},
    {4'd5, 1'b0, 10'h12C, 32'h9ABCDEF0},
    {4'd5, 1'b1, 10'h12C, 32'h9ABCDEF0},
    // R9 32-bit mode clears upper comparator
    {4'd9, 1'b0, 10'h120, 32'h00000100},
    {4'd9, 1'b1, 10'h12C, 32'h00000000},
    {4'd9, 1'b1, 10'h128, 32'h12345678},
    // R6 unimplemented slots
    {4'd6, 1'b0, 10'h160, 32'hFFFFFFFF},
    {4'd6, 1'b1, 10'h160, 32'h00000000},
    {4'd6, 1'b1, 10'h3E8, 32'h00000000},
    {4'd6, 1'b1, 10'h100, 32'h00000030},
    {4'd6, 1'b1, 10'h140, 32'h00000030},
    // R3 counter halves while stopped
    {4'd3, 1'b0, 10'h0F0, 32'hFFFFFFF0},
    {4'd3, 1'b0, 10'h0F4, 32'h00000001},
    {4'd3, 1'b1, 10'h0F0, 32'hFFFFFFF0},
    {4'd3, 1'b1, 10'h0F4, 32'h00000001}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input logic [2:0] p);
    ch_irq_pulse = p;
    @(negedge clk);
    ch_irq_pulse = '0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R1 arm idle", {61'd0, ch_arm}, 64'd0);
    check("R1 irq idle", {32'd0, irq_lines}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) begin
        rd(VEC[i][41:32], d);
        check($sformatf("R%0d vec%0d", VEC[i][46:43], i), {32'd0, d}, {32'd0, VEC[i][31:0]});
      end else begin
        wr(VEC[i][41:32], VEC[i][31:0]);
      end
    end
    wr(10'h120, 32'h0);

    // R12 read data holds
    repeat (3) @(negedge clk);
    check("R12 hold", {32'd0, rd_data}, 64'h1);

    // R2/R7 enable edge, count with carry, freeze
    wr(10'h010, 32'h1);
    check("R7 arm on rise", {61'd0, ch_arm}, 64'h2);
    check("R7 no disarm", {61'd0, ch_disarm}, 64'h0);
    repeat (9) @(negedge clk);
    check("R7 arm one cycle", {61'd0, ch_arm}, 64'h0);
    repeat (22) @(negedge clk);
    wr(10'h010, 32'h0);
    check("R7 disarm all", {61'd0, ch_disarm}, 64'h7);
    rd(10'h0F0, d); check("R2 lo after run", {32'd0, d}, 64'h10);
    rd(10'h0F4, d); check("R2 carry hi", {32'd0, d}, 64'h2);
    repeat (5) @(negedge clk);
    rd(10'h0F0, d); check("R2 frozen", {32'd0, d}, 64'h10);
    wr(10'h010, 32'h1);
    repeat (3) @(negedge clk);
    wr(10'h010, 32'h0);
    rd(10'h0F0, d); check("R2 resume", {32'd0, d}, 64'h14);

    // R3 write while counting
    wr(10'h010, 32'h1);
    wr(10'h0F4, 32'h5);
    repeat (4) @(negedge clk);
    wr(10'h010, 32'h0);
    rd(10'h0F4, d); check("R3 hi while running", {32'd0, d}, 64'h5);

    // R8 strobes, R10 routing
    wr(10'h100, 32'h00000A04);
    check("R8 cfg strobe", {61'd0, ch_cfg_wr}, 64'h1);
    wr(10'h120, 32'h00000E04);
    wr(10'h140, 32'h00000604);
    wr(10'h010, 32'h1);
    wr(10'h148, 32'h00000100);
    check("R8 cmp strobe", {61'd0, ch_cmp_wr}, 64'h4);
    check("R8 arm on cmp write", {61'd0, ch_arm}, 64'h4);
    pulse(3'b001); check("R10 ch0 route 5", {32'd0, irq_lines}, 64'h20);
    pulse(3'b010); check("R10 ch1 route 7", {32'd0, irq_lines}, 64'h80);
    @(negedge clk); check("R10 pulse clears", {32'd0, irq_lines}, 64'h0);
    wr(10'h010, 32'h3);
    check("R11 legacy on", {63'd0, legacy_mode}, 64'h1);
    pulse(3'b001); check("R10 legacy ch0", {32'd0, irq_lines}, 64'h1);
    pulse(3'b010); check("R10 legacy ch1", {32'd0, irq_lines}, 64'h100);
    pulse(3'b100); check("R10 legacy ch2 route", {32'd0, irq_lines}, 64'h8);
    wr(10'h140, 32'h00000600);
    pulse(3'b100); check("R10 int disabled", {32'd0, irq_lines}, 64'h0);
    wr(10'h010, 32'h2);
    pulse(3'b011); check("R10 global off", {32'd0, irq_lines}, 64'h0);
    wr(10'h010, 32'h0);
    check("R11 legacy off", {63'd0, legacy_mode}, 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule